// File: doc/BRIEF.md
# Compact Scan Escape and Activation Controller

This block sits beside a two-pin test access port. It watches the test clock (`tck`) and the bidirectional mode/data line (`tmsc`). It looks for escape sequences, which are bursts of data-line transitions made while the test clock is held high. It classifies each escape at the next test-clock rising edge. One class of escape starts an activation handshake. The block follows that handshake bit by bit through its named fields, and at the end it switches the port into the one-wire-data, three-phase scan mode (OSCAN1). A second class of escape returns the port to classic 4-wire operation.

The block does not use `tck` as a clock. Both pins are oversampled in the `clk` domain, and the callers are expected to have synchronized them already. Edges on the pins are found by comparing successive samples. The block tracks only where the activation sequence currently is, meaning the bit position and the field it falls in. It does not store or interpret the field contents. The outputs are:
- a mode code,
- the index of the field the latest activation bit belonged to,
- a single-cycle request to force the TAP controller to Test-Logic-Reset when OSCAN1 is entered.

Top module: `scan_escape_activator`

## Requirements
- R1: The escape count increases only on a `tmsc` change seen while `tck` was high in both the current and the previous sample. Changes made while `tck` is low have no effect on the mode.
- R2: At every `tck` rising edge the escape count is evaluated and then cleared. Transitions from separate high phases never add up.
- R3: An escape count of exactly 6 sets `mode` to 1 (activating), from any mode. The bit position restarts at 1 on that same rising edge, so `field` reads 1 (activation code), and the expected length becomes 12 bits.
- R4: An escape count of 8 or more sets `mode` to 0 (4-wire) from any mode, and `field` reads 0.
- R5: Escape counts of 0 to 5 and of 7 leave `mode` unchanged. During activation the bit position keeps advancing by one per rising edge.
- R6: The escape count saturates at 15. A burst of 22 transitions must act as a count of 8 or more, not as its value modulo 16 (which would be 6).
- R7: In a 12-bit sequence the field codes are: positions 1–4 give 1, positions 5–8 give 2 (extension control), positions 9–12 give 3 (check packet).
- R8: If `tmsc` is 0 at the rising edge that makes position 8, the sequence length becomes 36. From position 9 on, the field codes are:

  | Positions | Code |
  |---|---|
  | 9–13 | 4 |
  | 14–16 | 5 |
  | 17–18 | 6 |
  | 19–23 | 7 |
  | 24–25 | 8 |
  | 26–27 | 9 |
  | 28–32 | 10 |
  | 33–36 | 3 |

  If `tmsc` is 1 at that edge, the length stays 12.
- R9: The rising edge that moves the position past the sequence length sets `mode` to 2 (OSCAN1) and `field` to 0. It also raises `tapReset` for exactly one `clk` cycle. `tapReset` is not raised at any other time.
- R10: After reset, `mode` is 0, `field` is 0 and `tapReset` is 0. Whenever `mode` is not 1, `field` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tck | input | 1 | Test clock, already synchronized to `clk` |
| tmsc | input | 1 | Mode/data line, already synchronized to `clk` |
| mode | output | 2 | 0 = 4-wire, 1 = activating, 2 = OSCAN1 |
| field | output | 4 | Field code of the latest activation bit (0 when not activating) |
| tapReset | output | 1 | One-cycle request to force the TAP to Test-Logic-Reset |

## Verification
The bench uses the default parameters: a 4-bit escape counter, sequence lengths of 12 and 36, and the extension decision at position 8. With these values a 22-transition burst reaches the counter's saturation point, where a wrapping counter would read the activation value of 6, and both full field walks fit in a few hundred test-clock periods. The escape is placed in the high phase that comes just before the classifying edge. Because of this, restarts, aborts in mid-sequence and escapes from OSCAN1 are all exercised with a pending escape meeting a live activation sequence.

// File: rtl/scan_esc_pkg.sv
package scan_esc_pkg;

  typedef enum logic [1:0] {
    MODE_OFFLINE    = 2'd0,
    MODE_ACTIVATING = 2'd1,
    MODE_OSCAN1     = 2'd2
  } modeE;

  typedef enum logic [3:0] {
    FLD_NONE  = 4'd0,
    FLD_ACT   = 4'd1,
    FLD_EXT   = 4'd2,
    FLD_CHK   = 4'd3,
    FLD_RSV   = 4'd4,
    FLD_PDLY  = 4'd5,
    FLD_PREV  = 4'd6,
    FLD_PSTAT = 4'd7,
    FLD_RDY   = 4'd8,
    FLD_DLY   = 4'd9,
    FLD_FMT   = 4'd10
  } fieldE;

  // Last position of each field (positions count from 1)
  localparam int ACT_END   = 4;
  localparam int EXT_END   = 8;
  localparam int RSV_END   = 13;
  localparam int PDLY_END  = 16;
  localparam int PREV_END  = 18;
  localparam int PSTAT_END = 23;
  localparam int RDY_END   = 25;
  localparam int DLY_END   = 27;
  localparam int FMT_END   = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearEsc;  // evaluate-and-clear the escape counter
    logic restart;   // start a new activation sequence at this edge
    logic step;      // advance the bit position at this edge
  } strobeS;

endpackage

// File: rtl/scan_esc_datapath.sv
module scan_esc_datapath
  import scan_esc_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int SHORT_LEN  = 12,
  parameter int LONG_LEN   = 36,
  parameter int EXTEND_POS = 8,
  localparam int POS_W     = $clog2(LONG_LEN + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tck,
  input  logic             tmsc,
  input  strobeS           strobe,
  input  logic             activeMode,
  output logic             tckRise,
  output logic [CNT_W-1:0] escCount,
  output logic             overrun,
  output fieldE            field
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [POS_W-1:0] SHORT_P = POS_W'(SHORT_LEN);
  localparam logic [POS_W-1:0] LONG_P  = POS_W'(LONG_LEN);
  localparam logic [POS_W-1:0] EXT_P   = POS_W'(EXTEND_POS);

  logic tckQ, tckP, tmscQ, tmscP;
  logic escToggle;
  logic [POS_W-1:0] posQ, lenQ;
  logic [POS_W-1:0] posStep, lenBase, lenNext;
  logic extendNow;

  // Pin sampling and edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tckQ  <= 1'b0;
      tckP  <= 1'b0;
      tmscQ <= 1'b1;
      tmscP <= 1'b1;
    end else begin
      tckQ  <= tck;
      tckP  <= tckQ;
      tmscQ <= tmsc;
      tmscP <= tmscQ;
    end
  end

  assign tckRise   = tckQ & ~tckP;
  assign escToggle = (tmscQ ^ tmscP) & tckQ & tckP;

  // Saturating escape counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                escCount <= '0;
    else if (strobe.clearEsc) escCount <= '0;
    else if (escToggle && escCount != CNT_MAX)
      escCount <= escCount + 1'b1;
  end

  // Position and length tracking
  always_comb begin
    posStep   = (strobe.restart ? '0 : posQ) + 1'b1;
    lenBase   = strobe.restart ? SHORT_P : lenQ;
    extendNow = strobe.step && (posStep == EXT_P) && !tmscQ;
    lenNext   = extendNow ? LONG_P : lenBase;
    overrun   = strobe.step && (posStep > lenNext);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posQ <= '0;
      lenQ <= SHORT_P;
    end else if (strobe.step) begin
      posQ <= posStep;
      lenQ <= lenNext;
    end
  end

  // Field decode from position and length
  always_comb begin
    field = FLD_NONE;
    if (activeMode && posQ != '0) begin
      if (posQ <= POS_W'(ACT_END))      field = FLD_ACT;
      else if (posQ <= POS_W'(EXT_END)) field = FLD_EXT;
      else if (lenQ == SHORT_P) begin
        if (posQ <= SHORT_P) field = FLD_CHK;
      end else begin
        if      (posQ <= POS_W'(RSV_END))   field = FLD_RSV;
        else if (posQ <= POS_W'(PDLY_END))  field = FLD_PDLY;
        else if (posQ <= POS_W'(PREV_END))  field = FLD_PREV;
        else if (posQ <= POS_W'(PSTAT_END)) field = FLD_PSTAT;
        else if (posQ <= POS_W'(RDY_END))   field = FLD_RDY;
        else if (posQ <= POS_W'(DLY_END))   field = FLD_DLY;
        else if (posQ <= POS_W'(FMT_END))   field = FLD_FMT;
        else if (posQ <= LONG_P)            field = FLD_CHK;
      end
    end
  end

  // R6: a saturated counter stays put until it is cleared
  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(escCount) == CNT_MAX && !$past(strobe.clearEsc)) |-> escCount == CNT_MAX);

  // R2: the counter is empty after every evaluation
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearEsc |=> escCount == '0);

  // R8: the length register only ever holds one of the two legal lengths
  p_len_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lenQ == SHORT_P) || (lenQ == LONG_P));

endmodule

// File: rtl/scan_esc_ctrl.sv
module scan_esc_ctrl
  import scan_esc_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ACT_COUNT = 6,
  parameter int OFF_COUNT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tckRise,
  input  logic [CNT_W-1:0] escCount,
  input  logic             overrun,
  output strobeS           strobe,
  output modeE             mode,
  output logic             activeMode,
  output logic             tapReset
);

  localparam logic [CNT_W-1:0] ACT_C = CNT_W'(ACT_COUNT);
  localparam logic [CNT_W-1:0] OFF_C = CNT_W'(OFF_COUNT);

  logic goOff, goAct;
  modeE modeAfter, modeNext;

  always_comb begin
    goOff = tckRise && (escCount >= OFF_C);
    goAct = tckRise && !goOff && (escCount == ACT_C);
    if (goOff)      modeAfter = MODE_OFFLINE;
    else if (goAct) modeAfter = MODE_ACTIVATING;
    else            modeAfter = mode;
    strobe.clearEsc = tckRise;
    strobe.restart  = goAct;
    strobe.step     = tckRise && (modeAfter == MODE_ACTIVATING);
    modeNext        = (strobe.step && overrun) ? MODE_OSCAN1 : modeAfter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_OFFLINE;
      tapReset <= 1'b0;
    end else begin
      mode     <= modeNext;
      tapReset <= strobe.step && overrun;
    end
  end

  assign activeMode = (mode == MODE_ACTIVATING);

  // R9: the reset request is a single-cycle pulse
  p_tap_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    tapReset |=> !tapReset);

  // R9: the reset request coincides with OSCAN1 being entered
  p_tap_mode_r9: assert property (@(posedge clk) disable iff (!rstN)
    tapReset |-> (mode == MODE_OSCAN1 && $past(mode) == MODE_ACTIVATING));

  // R4: a long escape always lands in 4-wire mode
  p_offline_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tckRise && escCount >= OFF_C) |=> mode == MODE_OFFLINE);

  // R5: without a test-clock rising edge, the mode never moves
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tckRise |=> $stable(mode));

  // R3: the activation count always opens a fresh sequence
  p_activate_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tckRise && escCount == ACT_C) |=> mode == MODE_ACTIVATING);

endmodule

// File: rtl/scan_escape_activator.sv
module scan_escape_activator
  import scan_esc_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter int ACT_COUNT  = 6,
  parameter int OFF_COUNT  = 8,
  parameter int SHORT_LEN  = 12,
  parameter int LONG_LEN   = 36,
  parameter int EXTEND_POS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tck,
  input  logic       tmsc,
  output logic [1:0] mode,
  output logic [3:0] field,
  output logic       tapReset
);

  strobeS strobe;
  logic tckRise, overrun, activeMode;
  logic [CNT_W-1:0] escCount;
  modeE modeQ;
  fieldE fieldQ;

  scan_esc_datapath #(
    .CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN), .EXTEND_POS(EXTEND_POS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tck(tck), .tmsc(tmsc),
    .strobe(strobe), .activeMode(activeMode),
    .tckRise(tckRise), .escCount(escCount), .overrun(overrun), .field(fieldQ)
  );

  scan_esc_ctrl #(
    .CNT_W(CNT_W), .ACT_COUNT(ACT_COUNT), .OFF_COUNT(OFF_COUNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tckRise(tckRise), .escCount(escCount),
    .overrun(overrun), .strobe(strobe), .mode(modeQ),
    .activeMode(activeMode), .tapReset(tapReset)
  );

  assign mode  = modeQ;
  assign field = fieldQ;

  // R10: field is blank outside activation
  p_field_blank_r10: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 2'd1) |-> field == 4'd0);

endmodule

// File: tb/scan_escape_activator_bench.sv
module scan_escape_activator_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tck = 1'b0;
  logic tmsc = 1'b1;
  logic [1:0] mode;
  logic [3:0] field;
  logic tapReset;

  int testsRun = 0;
  int testsFailed = 0;
  int tapPulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  scan_escape_activator u_scan_escape_activator (
    .clk(clk), .rstN(rstN), .tck(tck), .tmsc(tmsc),
    .mode(mode), .field(field), .tapReset(tapReset)
  );

  typedef struct {
    int    expMode;
    int    expField;
    int    expTaps;
    string tag;
  } itemT;

  itemT sbQ[$];

  // Reference model built from the requirements
  int mMode = 0, mPos = 0, mLen = 12, mTaps = 0, pendingEsc = 0;

  function automatic int fieldOf(int m, int p, int l);
    if (m != 1) return 0;
    if (p <= 4) return 1;
    if (p <= 8) return 2;
    if (l == 12) return (p <= 12) ? 3 : 0;
    if (p <= 13) return 4;
    if (p <= 16) return 5;
    if (p <= 18) return 6;
    if (p <= 23) return 7;
    if (p <= 25) return 8;
    if (p <= 27) return 9;
    if (p <= 32) return 10;
    return 3;
  endfunction

  task automatic modelEdge(input bit b, input int esc);
    if (esc >= 8) mMode = 0;
    else if (esc == 6) begin mMode = 1; mPos = 0; mLen = 12; end
    if (mMode == 1) begin
      mPos++;
      if (mPos == 8 && !b) mLen = 36;
      if (mPos > mLen) begin mMode = 2; mTaps++; end
    end
  endtask

  // Driver: one test-clock period
  task automatic cyc(input bit b, input int hiTog, input int loTog, input string tag);
    itemT it;
    for (int i = 0; i < loTog; i++) begin
      @(negedge clk); tmsc = ~tmsc;
      @(negedge clk);
    end
    @(negedge clk); tmsc = b;
    repeat (2) @(negedge clk);
    tck = 1'b1;
    modelEdge(b, pendingEsc);
    pendingEsc = 0;
    repeat (4) @(negedge clk);
    it.expMode = mMode; it.expField = fieldOf(mMode, mPos, mLen);
    it.expTaps = mTaps; it.tag = tag;
    sbQ.push_back(it);
    for (int i = 0; i < hiTog; i++) begin
      @(negedge clk); tmsc = ~tmsc;
      @(negedge clk);
    end
    pendingEsc = hiTog;
    @(negedge clk); tck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && tapReset) tapPulses++;
    if (sbQ.size() > 0) begin
      itemT it;
      it = sbQ.pop_front();
      testsRun++;
      if (mode != it.expMode[1:0] || field != it.expField[3:0] || tapPulses != it.expTaps) begin
        testsFailed++;
        $display("FAIL %s: mode=%0d field=%0d taps=%0d expected mode=%0d field=%0d taps=%0d",
                 it.tag, mode, field, tapPulses, it.expMode, it.expField, it.expTaps);
      end
    end
  end

  task automatic sequenceBits(input int count, input int extPosVal, input int escLast, input string tag);
    for (int i = 1; i <= count; i++)
      cyc((i == 8) ? extPosVal[0] : 1'b1, (i == count) ? escLast : 0, 0, tag);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testsRun++;
    if (mode != 2'd0 || field != 4'd0 || tapReset != 1'b0) begin
      testsFailed++;
      $display("FAIL R10: mode=%0d field=%0d tapReset=%0d expected 0 0 0", mode, field, tapReset);
    end

    cyc(1'b1, 0, 0, "R10 idle");
    cyc(1'b1, 0, 6, "R1 low toggles");
    cyc(1'b1, 0, 0, "R1 low toggles ignored");
    cyc(1'b1, 3, 0, "R2 split escape");
    cyc(1'b1, 3, 0, "R2 split escape first");
    cyc(1'b1, 7, 0, "R2 split escape second");
    cyc(1'b1, 5, 0, "R5 count 7 ignored");
    cyc(1'b1, 6, 0, "R5 count 5 ignored");
    // activation, short form, R3/R7/R9
    sequenceBits(12, 1, 0, "R7 short walk");
    cyc(1'b1, 0, 0, "R9 short finish");
    cyc(1'b1, 7, 0, "R9 oscan hold");
    cyc(1'b1, 6, 0, "R5 count 7 in oscan");
    // restart from OSCAN1, long form, R3/R8/R9
    sequenceBits(36, 0, 0, "R8 long walk");
    cyc(1'b1, 0, 0, "R8 long finish");
    cyc(1'b1, 8, 0, "R9 oscan hold again");
    cyc(1'b1, 6, 0, "R4 offline from oscan");
    // abort mid-sequence with an 8-count
    sequenceBits(5, 1, 8, "R3 start then abort");
    cyc(1'b1, 6, 0, "R4 offline mid-sequence");
    // restart mid-sequence with a 6-count, then a count of 2 keeps stepping
    sequenceBits(6, 1, 6, "R3 start");
    sequenceBits(3, 1, 2, "R3 restart mid-sequence");
    cyc(1'b1, 0, 0, "R5 count 2 keeps stepping");
    // saturation: 22 toggles must mean offline, not activation
    cyc(1'b1, 22, 0, "R5 count 0");
    cyc(1'b1, 0, 0, "R6 saturated escape");
    cyc(1'b1, 0, 0, "R6 stays offline");

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule